// File: doc/BRIEF.md
# Event Status and Enable Register Block

This block holds a small set of hardware event flags and their matching mask bits behind a fixed four-byte window in host I/O space. It raises one level-sensitive interrupt line while at least one flag is set and its mask bit is also set. Event sources pulse bits of `evt_i` to set flags. Software reads the flags, services the events and clears them by writing ones. Software also reads and writes the mask bits directly.

A host access carries one to four bytes. Internally it is handled as independent byte accesses in little-endian order: data lane k targets address `addr_i + k`. Any byte that lands outside the window is dropped. The interrupt level is recomputed on the same clock edge that commits a byte write or an event. The block is used as interrupt line 9 by the surrounding platform. That number is a system-level assignment and does not change the logic of the block.

Top module: `event_irq_regs`

## Requirements
- R1: While reset is asserted and right after it is released, every flag bit and every mask bit is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: The window starts at base address 0xAFE0 and is 4 bytes long. The flags sit at offset 0 (bits 7:0) and offset 1 (bits 15:8). The masks sit at offset 2 (bits 7:0) and offset 3 (bits 15:8).
- R3: `size_i` = n selects n+1 bytes. Byte lane k, taken from `wdata_i[8k+7:8k]` or returned on `rdata_o[8k+7:8k]`, addresses `addr_i + k`. Only lanes k ≤ n take part.
- R4: A lane whose address falls outside the window has no effect on a write and reads back as 0x00.
- R5: Writing 1 to a flag bit clears that bit. Writing 0 leaves it unchanged.
- R6: Mask bytes are plain read/write storage. They change only on a write that hits them.
- R7: A 1 on `evt_i[b]` sets flag bit b on the next clock edge. If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: After any clock edge, `irq_o` equals the OR over all bits of (flag AND mask). It is updated on the same edge that changes the flags or masks.
- R9: `rdata_o` is loaded on an edge where `rd_en_i` is 1 and holds its value otherwise. Nothing changes on an edge where `wr_en_i` is 0 and `evt_i` is 0.
- R10: If a read and a write happen in the same cycle, the read returns the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host byte address of lane 0 |
| size_i | input | 2 | Access size minus one, in bytes |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data, little-endian lanes |
| rdata_o | output | 32 | Registered read data, little-endian lanes |
| evt_i | input | 16 | Event requests, one per flag bit |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every start offset from two bytes below the window to two bytes past its end, with every access size. This shows that partially overlapping accesses keep only their in-window lanes. A design that wrapped the offset or ignored the lane count would corrupt the masks or return stray bytes. Flags are set by events and then cleared by writes at every offset and size. A design that treated the flags as plain storage would leave bits set that should be cleared, or set bits that should stay clear. Directed cases cover an event and a clear on the same bit in the same cycle, and a read issued in the same cycle as a write. Getting the first wrong loses an event. Getting the second wrong returns post-write data.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Byte offset of lane k relative to the window base; wraps for addresses
  // below the base so they land far outside the window.
  function automatic logic [31:0] lane_offset(input logic [31:0] addr,
                                              input logic [31:0] base,
                                              input int unsigned k);
    return addr + 32'(k) - base;
  endfunction

  // Lane k takes part when the encoded size (bytes minus one) reaches it.
  function automatic logic lane_active(input logic [1:0] size_m1,
                                       input int unsigned k);
    return 32'(size_m1) >= 32'(k);
  endfunction

  // Interrupt level: any flag with its mask bit set.
  function automatic logic irq_level(input logic [15:0] flags,
                                     input logic [15:0] masks);
    return |(flags & masks);
  endfunction

endpackage

// File: rtl/evt_lane_decode.sv
module evt_lane_decode #(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE      = 16'hAFE0,
  parameter int unsigned        REG_BYTES = 4,
  parameter int unsigned        LANES     = 4,
  localparam int unsigned       SZ_W      = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [SZ_W-1:0]      size_i,
  input  logic                 wr_en_i,
  input  logic [8*LANES-1:0]   wdata_i,
  output logic [REG_BYTES-1:0] byte_wr_o,
  output logic [8*REG_BYTES-1:0] byte_data_o
);
  import evt_pkg::*;

  for (genvar r = 0; r < REG_BYTES; r++) begin : g_reg
    always_comb begin
      byte_wr_o[r]           = 1'b0;
      byte_data_o[8*r +: 8]  = 8'h00;
      for (int unsigned k = 0; k < LANES; k++) begin
        if (wr_en_i && lane_active(2'(size_i), k) &&
            lane_offset(32'(addr_i), 32'(BASE), k) == 32'(r)) begin
          byte_wr_o[r]          = 1'b1;
          byte_data_o[8*r +: 8] = wdata_i[8*k +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/evt_reg_bank.sv
module evt_reg_bank #(
  parameter int unsigned  FLAG_BYTES = 2,
  localparam int unsigned N_BITS     = 8*FLAG_BYTES,
  localparam int unsigned REG_BYTES  = 2*FLAG_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [REG_BYTES-1:0]   byte_wr_i,
  input  logic [8*REG_BYTES-1:0] byte_data_i,
  input  logic [N_BITS-1:0]      evt_i,
  output logic [N_BITS-1:0]      flags_q_o,
  output logic [N_BITS-1:0]      masks_q_o,
  output logic [N_BITS-1:0]      flags_d_o,
  output logic [N_BITS-1:0]      masks_d_o,
  output logic [N_BITS-1:0]      clr_mask_o
);
  logic [N_BITS-1:0] flags_q, masks_q;

  for (genvar b = 0; b < FLAG_BYTES; b++) begin : g_byte
    // flag byte b lives at offset b, its mask byte at offset FLAG_BYTES+b
    assign clr_mask_o[8*b +: 8] = byte_wr_i[b] ? byte_data_i[8*b +: 8] : 8'h00;
    assign masks_d_o[8*b +: 8]  = byte_wr_i[FLAG_BYTES+b]
                                  ? byte_data_i[8*(FLAG_BYTES+b) +: 8]
                                  : masks_q[8*b +: 8];
  end

  // an event wins over a clear of the same bit
  assign flags_d_o = (flags_q & ~clr_mask_o) | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      masks_q <= '0;
    end else begin
      flags_q <= flags_d_o;
      masks_q <= masks_d_o;
    end
  end

  assign flags_q_o = flags_q;
  assign masks_q_o = masks_q;

endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int unsigned N_BITS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] flags_d_i,
  input  logic [N_BITS-1:0] masks_d_i,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flags_d_i & masks_d_i);
  end
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux #(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE      = 16'hAFE0,
  parameter int unsigned        REG_BYTES = 4,
  parameter int unsigned        LANES     = 4,
  localparam int unsigned       SZ_W      = $clog2(LANES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [SZ_W-1:0]        size_i,
  input  logic                   rd_en_i,
  input  logic [8*REG_BYTES-1:0] regs_i,
  output logic [8*LANES-1:0]     rdata_o
);
  import evt_pkg::*;

  logic [8*LANES-1:0] rd_next;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      rd_next[8*k +: 8] = 8'h00;
      for (int unsigned r = 0; r < REG_BYTES; r++) begin
        if (lane_active(2'(size_i), k) &&
            lane_offset(32'(addr_i), 32'(BASE), k) == 32'(r))
          rd_next[8*k +: 8] = regs_i[8*r +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/event_irq_regs.sv
module event_irq_regs #(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE       = 16'hAFE0,
  parameter int unsigned       FLAG_BYTES = 2,
  parameter int unsigned       LANES      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [15:0]       evt_i,
  output logic              irq_o
);
  localparam int unsigned N_BITS    = 8*FLAG_BYTES;
  localparam int unsigned REG_BYTES = 2*FLAG_BYTES;

  logic [REG_BYTES-1:0]   byte_wr;
  logic [8*REG_BYTES-1:0] byte_data;
  logic [N_BITS-1:0]      flags_q, masks_q, flags_d, masks_d, clr_mask;

  evt_lane_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .REG_BYTES(REG_BYTES),
                    .LANES(LANES)) u_dec (
    .addr_i(addr_i), .size_i(size_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .byte_wr_o(byte_wr), .byte_data_o(byte_data));

  evt_reg_bank #(.FLAG_BYTES(FLAG_BYTES)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_wr_i(byte_wr),
    .byte_data_i(byte_data), .evt_i(evt_i), .flags_q_o(flags_q),
    .masks_q_o(masks_q), .flags_d_o(flags_d), .masks_d_o(masks_d),
    .clr_mask_o(clr_mask));

  evt_irq_gen #(.N_BITS(N_BITS)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .flags_d_i(flags_d),
    .masks_d_i(masks_d), .irq_o(irq_o));

  evt_read_mux #(.ADDR_W(ADDR_W), .BASE(BASE), .REG_BYTES(REG_BYTES),
                 .LANES(LANES)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .size_i(size_i),
    .rd_en_i(rd_en_i), .regs_i({masks_q, flags_q}), .rdata_o(rdata_o));

endmodule

// File: rtl/event_irq_regs_chk.sv
module event_irq_regs_chk #(
  parameter int unsigned N_BITS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [N_BITS-1:0] evt_i,
  input logic [N_BITS-1:0] flags_q,
  input logic [N_BITS-1:0] masks_q,
  input logic [N_BITS-1:0] clr_mask,
  input logic              irq_o,
  input logic [31:0]       rdata_o
);
  // R8: interrupt level tracks the committed flag and mask state
  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == evt_pkg::irq_level(16'(flags_q), 16'(masks_q))));

  // R7: every requested event is visible as a set flag after the edge
  a_r7_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  // R5: a flag only falls where a write-one-to-clear hit it
  a_r5_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(flags_q) & ~flags_q) & ~$past(clr_mask)) == '0));

  // R6: masks hold without a write
  a_r6_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(masks_q));

  // R9: read data holds without a read strobe
  a_r9_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R9: idle cycle leaves flags untouched
  a_r9_idle_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(|evt_i)) |=> $stable(flags_q));
endmodule

bind event_irq_regs event_irq_regs_chk #(.N_BITS(16)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .evt_i(evt_i), .flags_q(flags_q), .masks_q(masks_q), .clr_mask(clr_mask),
  .irq_o(irq_o), .rdata_o(rdata_o));

// File: tb/event_irq_regs_bench.sv
module event_irq_regs_bench;
  localparam logic [15:0] BASE = 16'hAFE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  size = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] evt = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m = '0;   // model: byte0/1 flags, byte2/3 masks

  always #4 clk = ~clk;

  event_irq_regs u_event_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .evt_i(evt), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_irq();
    return |(m[15:0] & m[31:16]);
  endfunction

  // apply a write to the model: per lane, in-window bytes only
  function automatic void model_write(input logic [15:0] a, input int sz, input logic [31:0] d);
    for (int k = 0; k <= sz; k++) begin
      int off = int'(a) + k - int'(BASE);
      if (off >= 0 && off < 2) m[8*off +: 8] = m[8*off +: 8] & ~d[8*k +: 8];
      else if (off >= 2 && off < 4) m[8*off +: 8] = d[8*k +: 8];
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a, input int sz);
    logic [31:0] r = '0;
    for (int k = 0; k <= sz; k++) begin
      int off = int'(a) + k - int'(BASE);
      if (off >= 0 && off < 4) r[8*k +: 8] = m[8*off +: 8];
    end
    return r;
  endfunction

  task automatic host_write(input logic [15:0] a, input int sz, input logic [31:0] d,
                            input logic [15:0] ev);
    @(negedge clk);
    addr = a; size = 2'(sz); wdata = d; wr_en = 1'b1; evt = ev;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    model_write(a, sz, d);
    m[15:0] = m[15:0] | ev;
    chk("R8 irq after write", {31'b0, irq}, {31'b0, model_irq()});
  endtask

  task automatic host_read(input string req, input logic [15:0] a, input int sz);
    @(negedge clk);
    addr = a; size = 2'(sz); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, model_read(a, sz));
  endtask

  task automatic pulse_evt(input logic [15:0] ev);
    @(negedge clk);
    evt = ev;
    @(negedge clk);
    evt = '0;
    m[15:0] = m[15:0] | ev;
    chk("R7 irq after event", {31'b0, irq}, {31'b0, model_irq()});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    chk("R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    host_read("R1 state after reset", BASE, 3);

    // R2 R3 R4 R6: mask writes at every offset and size, read back whole window
    for (int off = -2; off <= 5; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] d = 32'h1357_9BDF + 32'(sz * 32'h0101_0101) + 32'(off * 32'h0011_2233);
        host_write(16'(int'(BASE) + off), sz, d, 16'h0);
        host_read("R6 window after write", BASE, 3);
      end
    end

    // R4 R3: reads at every offset and size
    pulse_evt(16'hC3A5);
    for (int off = -2; off <= 5; off++)
      for (int sz = 0; sz < 4; sz++)
        host_read("R4 partial read", 16'(int'(BASE) + off), sz);

    // R5: flag clears at every offset and size after refilling
    for (int off = -2; off <= 5; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        pulse_evt(16'hFFFF);
        host_write(16'(int'(BASE) + off), sz, 32'h5A3C_96F0 ^ 32'(sz), 16'h0);
        host_read("R5 flags after clear", BASE, 3);
      end
    end

    // R8: irq follows single flag/mask pairing
    host_write(BASE, 3, 32'h0000_FFFF, 16'h0);
    chk("R8 irq low all clear", {31'b0, irq}, 32'h0);
    pulse_evt(16'h0100);
    chk("R8 irq low unmasked", {31'b0, irq}, 32'h0);
    host_write(BASE + 16'd3, 0, 32'h0000_0001, 16'h0);
    chk("R8 irq high masked in", {31'b0, irq}, 32'h1);
    host_write(BASE + 16'd1, 0, 32'h0000_0001, 16'h0);
    chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

    // R7: event and clear of the same bit in one cycle
    pulse_evt(16'h0100);
    host_write(BASE, 1, 32'h0000_0100, 16'h0100);
    host_read("R7 event beats clear", BASE, 3);
    chk("R7 irq kept", {31'b0, irq}, 32'h1);

    // R10: read in same cycle as write returns old values
    @(negedge clk);
    addr = BASE; size = 2'd3; wdata = 32'hAA55_0000; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read before write", rdata, model_read(BASE, 3));
    model_write(BASE, 3, 32'hAA55_0000);
    host_read("R10 write committed", BASE, 3);

    // R9: idle cycles change nothing, rdata holds
    host_read("R9 pre idle", BASE, 3);
    repeat (4) @(negedge clk);
    chk("R9 rdata held", rdata, model_read(BASE, 3));
    host_read("R9 state after idle", BASE, 3);

    finish_run();
  end
endmodule